// File: doc/BRIEF.md
# Two-Tier Carry Look-Ahead Adder (16 bits)

This block is a purely combinational adder for two 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. Instead of letting a carry ripple from bit to bit, it splits the operands into four slices of four bits. Each bit first forms a propagate term (the OR of its operand bits) and a generate term (the AND of its operand bits). Each slice condenses its four pairs into one slice-level propagate and one slice-level generate. A second-tier look-ahead unit uses the same four-input carry equations to turn those slice pairs and the carry-in into the carry that enters each upper slice.

Each slice then expands its entering carry into the carries of its own three upper bits. The lowest slice takes the external carry-in directly, so its carries never wait on the second tier. Every sum bit is the XOR of its two raw operand bits and its carry. The carry-out comes from the second-tier unit. The nominal path is nine gate levels: one for bit propagate/generate, two for the slice pairs, two for the entering carries, two for the carries inside a slice, and two for the sums.

Top module: `cla16_adder`

## Requirements
- R1: For every input combination, `{carry_out, sum}` equals the 17-bit value `op_a + op_b + carry_in`.
- R2: A bit position where both operand bits are 1 produces a carry into the next bit whatever its incoming carry (0x0001 + 0x0001 with carry_in 0 gives sum 0x0002).
- R3: A carry entering a run of bits in which exactly one operand bit is 1 passes through the whole run (0xFFFF + 0x0000 with carry_in 1 gives sum 0x0000 and carry_out 1).
- R4: The carry entering each upper slice equals the carry leaving the slice below it (0x0008 + 0x0008 gives 0x0010, and 0x0888 + 0x0888 gives 0x1110).
- R5: The lowest slice uses carry_in directly (0x0000 + 0x0000 with carry_in 1 gives sum 0x0001).
- R6: Each sum bit is the XOR of the two operand bits and the carry into that bit (0x5555 + 0xAAAA gives 0xFFFF with carry_out 0 when carry_in is 0, and 0x0000 with carry_out 1 when carry_in is 1).
- R7: 0xFFFF + 0xFFFF with carry_in 1 gives sum 0xFFFF and carry_out 1.
- R8: 0x0000 + 0x0000 with carry_in 0 gives sum 0x0000 and carry_out 0.
- R9: carry_out equals the carry leaving the top slice: it is 1 whenever the top slice generates, and it follows carry_in whenever every slice propagates without generating (0x8000 + 0x8000 gives sum 0x0000 and carry_out 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Several properties are checked on every input change by the assertions in the RTL. A bit never generates without also propagating. Each upper slice receives the same carry that the slice below it computes on its own. The second-tier carry-out matches the top slice's own carry-out and obeys the top-level generate and propagate terms. The full 17-bit total matches the arithmetic sum. The bench's scenarios add to this. Long propagate chains through all sixteen bits, generate at slice boundaries, alternating patterns with both carry-in values, and the extreme operands only show up in chosen vectors. Those vectors are compared against a behavioural integer reference together with random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Bits per slice; the second tier also spans this many slices.
  parameter int GRP_W = 4;

  // Bit-level propagate: an incoming carry passes through this bit.
  function automatic logic bit_prop(input logic a, input logic b);
    return a | b;
  endfunction

  // Bit-level generate: this bit emits a carry whatever enters it.
  function automatic logic bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  // Flat two-level carry leaving position idx of a slice:
  // OR over j<=idx of g[j] & p[j+1..idx], plus cin & p[0..idx].
  function automatic logic la_carry(input logic [GRP_W-1:0] p,
                                    input logic [GRP_W-1:0] g,
                                    input logic             cin,
                                    input int               idx);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < GRP_W; j++) begin
      if (j <= idx) begin
        prod = g[j];
        for (int k = 0; k < GRP_W; k++) begin
          if (k > j && k <= idx) prod = prod & p[k];
        end
        acc = acc | prod;
      end
    end
    prod = cin;
    for (int k = 0; k < GRP_W; k++) begin
      if (k <= idx) prod = prod & p[k];
    end
    return acc | prod;
  endfunction

  // Slice generate: carry out of the slice with a zero carry-in.
  function automatic logic grp_gen(input logic [GRP_W-1:0] p,
                                   input logic [GRP_W-1:0] g);
    return la_carry(p, g, 1'b0, GRP_W-1);
  endfunction

  // Slice propagate: every bit of the slice passes a carry.
  function automatic logic grp_prop(input logic [GRP_W-1:0] p);
    return &p;
  endfunction

  // Sum bit from raw operand bits and the carry into the bit.
  function automatic logic sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] p,
  output logic [WIDTH-1:0] g
);
  import cla_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p[i] = bit_prop(a[i], b[i]);
    assign g[i] = bit_gen(a[i], b[i]);
  end

endmodule

// File: rtl/cla_lookahead.sv
// One four-input look-ahead unit. The first tier uses it on bit pairs and
// the second tier on slice pairs, with identical equations.
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W:1]   carry,
  output logic         grp_p,
  output logic         grp_g
);

  for (genvar i = 0; i < W; i++) begin : g_carry
    assign carry[i+1] = la_carry(p, g, cin, i);
  end

  // The slice pair does not depend on cin.
  assign grp_p = grp_prop(p);
  assign grp_g = grp_gen(p, g);

  always_comb begin
    if (grp_p && !grp_g) begin
      AST_GROUP_PASS: assert (carry[W] == cin)
        else $error("slice propagates without generating but carry-out differs from carry-in"); // R3
    end
    if (grp_g) begin
      AST_GROUP_GEN: assert (carry[W])
        else $error("slice generates but carry-out is low"); // R2
    end
  end

endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] cbit,
  output logic [WIDTH-1:0] s
);
  import cla_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign s[i] = sum_bit(a[i], b[i], cbit[i]);
  end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int GW = GRP_W,
  localparam int NG = GW,
  localparam int WIDTH = GW * NG
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  // Per-bit terms.
  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_g;

  // First-tier results, one entry per slice.
  logic [GW:1]      slice_carry [NG];
  logic [NG-1:0]    slice_p;
  logic [NG-1:0]    slice_g;
  logic [NG-1:0]    slice_cout;

  // Second-tier results: entering carries and the top-level pair.
  logic [NG:1]      seed_carry;
  logic [NG-1:0]    slice_seed;
  logic             top_p;
  logic             top_g;

  // Carry into every bit position.
  logic [WIDTH-1:0] bit_cin;

  cla_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a (op_a),
    .b (op_b),
    .p (bit_p),
    .g (bit_g)
  );

  for (genvar k = 0; k < NG; k++) begin : g_slice
    // The lowest slice takes the external carry straight in.
    if (k == 0) begin : g_low
      assign slice_seed[k] = carry_in;
    end else begin : g_up
      assign slice_seed[k] = seed_carry[k];
    end

    cla_lookahead #(.W(GW)) u_tier1 (
      .p     (bit_p[k*GW +: GW]),
      .g     (bit_g[k*GW +: GW]),
      .cin   (slice_seed[k]),
      .carry (slice_carry[k]),
      .grp_p (slice_p[k]),
      .grp_g (slice_g[k])
    );

    assign slice_cout[k]   = slice_carry[k][GW];
    assign bit_cin[k*GW]   = slice_seed[k];
    for (genvar i = 1; i < GW; i++) begin : g_inner
      assign bit_cin[k*GW + i] = slice_carry[k][i];
    end
  end

  cla_lookahead #(.W(NG)) u_tier2 (
    .p     (slice_p),
    .g     (slice_g),
    .cin   (carry_in),
    .carry (seed_carry),
    .grp_p (top_p),
    .grp_g (top_g)
  );

  cla_sum #(.WIDTH(WIDTH)) u_sum (
    .a    (op_a),
    .b    (op_b),
    .cbit (bit_cin),
    .s    (sum)
  );

  assign carry_out = seed_carry[NG];

  always_comb begin
    AST_GEN_IMPLIES_PROP: assert ((bit_g & ~bit_p) == '0)
      else $error("a bit generates without propagating"); // R2
    for (int k = 1; k < NG; k++) begin
      AST_SEED_CHAIN: assert (slice_seed[k] == slice_cout[k-1])
        else $error("slice %0d entering carry differs from slice below", k); // R4
    end
    AST_LOW_SEED: assert (bit_cin[0] == carry_in)
      else $error("bit 0 carry differs from carry_in"); // R5
    AST_C16_TOP_SLICE: assert (carry_out == slice_cout[NG-1])
      else $error("carry_out differs from top slice carry"); // R9
    if (top_g) begin
      AST_TOP_GEN: assert (carry_out)
        else $error("top generate set but carry_out low"); // R9
    end
    if (top_p && !top_g) begin
      AST_TOP_PASS: assert (carry_out == carry_in)
        else $error("full propagate but carry_out differs from carry_in"); // R9
    end
    AST_SUM_TOTAL: assert ({carry_out, sum} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("total differs from arithmetic sum"); // R1
  end

endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;
  localparam int N_RANDOM = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla16_adder uut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  // Behavioural reference: integer addition.
  function automatic int ref_total(input logic [15:0] a, input logic [15:0] b,
                                   input logic c);
    return int'(a) + int'(b) + int'(c);
  endfunction

  task automatic compare(input string req, input int exp_total);
    checks++;
    if (int'({carry_out, sum}) != exp_total) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got carry=%b sum=%h expected total=%h",
               req, op_a, op_b, carry_in, carry_out, sum, exp_total[16:0]);
    end
  endtask

  // Drive just after a rising edge, sample at the following falling edge.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input int exp_total, input string req);
    @(posedge clk);
    op_a     <= a;
    op_b     <= b;
    carry_in <= c;
    @(negedge clk);
    compare(req, exp_total);
    // Reference model checked on every applied vector as well.
    if (exp_total != ref_total(a, b, c)) begin
      checks++;
      errors++;
      $display("FAIL %s: stated expectation %h disagrees with reference %h",
               req, exp_total, ref_total(a, b, c));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // Reset-state check: zero inputs give zero outputs (R8).
    @(negedge clk);
    compare("R8 reset", 0);
    rst_n <= 1'b1;

    apply(16'h0000, 16'h0000, 1'b0, 'h00000, "R8");
    apply(16'h0001, 16'h0001, 1'b0, 'h00002, "R2");
    apply(16'h00F0, 16'h00F0, 1'b1, 'h001E1, "R2");
    apply(16'hFFFF, 16'h0000, 1'b1, 'h10000, "R3");
    apply(16'h0000, 16'hFFFF, 1'b1, 'h10000, "R3");
    apply(16'hFFFF, 16'h0001, 1'b0, 'h10000, "R3");
    apply(16'h0008, 16'h0008, 1'b0, 'h00010, "R4");
    apply(16'h0888, 16'h0888, 1'b0, 'h01110, "R4");
    apply(16'h0FFF, 16'h0000, 1'b1, 'h01000, "R4");
    apply(16'h0000, 16'h0000, 1'b1, 'h00001, "R5");
    apply(16'h000F, 16'h0000, 1'b1, 'h00010, "R5");
    apply(16'h5555, 16'hAAAA, 1'b0, 'h0FFFF, "R6");
    apply(16'h5555, 16'hAAAA, 1'b1, 'h10000, "R6");
    apply(16'h1234, 16'h0F0F, 1'b0, 'h02143, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 'h1FFFF, "R7");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 'h1FFFE, "R7");
    apply(16'h8000, 16'h8000, 1'b0, 'h10000, "R9");
    apply(16'hF000, 16'h1000, 1'b0, 'h10000, "R9");
    apply(16'h7FFF, 16'h8000, 1'b0, 'h0FFFF, "R9");

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      logic        rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc, ref_total(ra, rb, rc), "R1");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule